// File: doc/BRIEF.md
# Elastic Bit Buffer with Stuff Decision

This block moves a serial bit stream from the timing of its source (a recovered or encoder clock) into a framed system timing. Each source timing tick writes one bit into a small circular store and advances a write pointer. The frame control logic supplies gated read ticks. Each read tick copies the bit at the read pointer into a holding register and advances the read pointer. The held bit leaves through an output flip-flop. Both timings are modelled as enables of one clock, so the block has a single clock domain.

Once per minor frame a word strobe marks the comparison word. On the first cycle of that strobe, both pointers are copied into latches at the same instant. One cycle later, their modular difference is sorted into one of four verdicts: balanced, positive stuff (the read side is catching up on the write side), negative stuff (the write side is pulling ahead) or lost (outside tolerance). The positive stuff flag is masked while the comparison word is active. The negative stuff flag is active low and is never masked. A lost verdict raises a one-cycle realignment pulse and re-centres the read pointer half a store behind the write pointer.

Top module: `elastic_stuff_buffer`

## Requirements
- R1: Each cycle with `wr_tick` high stores `din` in the store cell addressed by the write pointer, and the write pointer then advances by one modulo 16. The write pointer moves on no other cycle.
- R2: The read pointer advances by one only on a cycle with `rd_tick` high, and only when no realignment occurs in that cycle. On that cycle the holding register takes the store cell at the read pointer as it stood before the edge.
- R3: `dout` equals the holding register delayed by one system clock, so a bit appears on `dout` two edges after the read tick that fetched it.
- R4: On the first cycle of each `word_mark` high period, the write and read pointers are latched together. A `word_mark` that stays high for several cycles latches only once.
- R5: One cycle after a latch, the verdict is updated from d = (latched write pointer − latched read pointer) mod 16. The verdict is lost if d ≤ 2 or d ≥ 14, positive stuff if 3 ≤ d ≤ 5, balanced if 6 ≤ d ≤ 10, and negative stuff if 11 ≤ d ≤ 13. The verdict holds until the next update. At most one stuff flag is active at a time.
- R6: `pos_stuff` is high exactly when the verdict is positive stuff and `word_mark` is low.
- R7: `neg_stuff_n` is low exactly when the verdict is negative stuff, whatever the level of `word_mark`.
- R8: A lost verdict drives `reinit` high for one cycle, the cycle after the verdict update. In the update cycle itself, `rd_tick` is ignored and the read pointer becomes (the write pointer after that edge) − 8. Both stuff flags stay inactive until the next verdict.
- R9: After reset the write pointer is 0, the read pointer is 8, the store holds zeros and the verdict is balanced. The outputs are `dout`=0, `pos_stuff`=0, `neg_stuff_n`=1 and `reinit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial data from the source |
| wr_tick | input | 1 | Source timing tick: write one bit |
| rd_tick | input | 1 | Gated read tick from frame control |
| word_mark | input | 1 | High during the comparison word of each minor frame |
| dout | output | 1 | Retimed serial data |
| pos_stuff | output | 1 | Positive stuff request, masked during the comparison word |
| neg_stuff_n | output | 1 | Negative stuff request, active low |
| reinit | output | 1 | One-cycle pulse when the buffer is realigned |

## Verification
The block is driven with four tick patterns, and each one separates a different verdict path. Matched write and read rates hold the pointer gap at 8 and must give only balanced verdicts with every bit delivered intact. Dropping one read tick per frame makes the gap grow by one per frame; this pattern walks through the negative stuff band into the lost band and checks realignment. Adding one read tick per frame walks down through the positive stuff band, where the masking by `word_mark` becomes visible. A random phase mixes irregular ticks and long or short word strobes, which tests single latching and the case where a read tick is ignored during realignment.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    // Verdict of the once-per-frame pointer comparison.
    typedef enum logic [1:0] {
        VERDICT_BAL  = 2'd0,
        VERDICT_POS  = 2'd1,
        VERDICT_NEG  = 2'd2,
        VERDICT_LOST = 2'd3
    } verdict_e;

endpackage

// File: rtl/ebuf_store.sv
module ebuf_store #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);

    logic [DEPTH-1:0] cells_d;
    logic [DEPTH-1:0] cells_q;

    // One next-value term per cell.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        always_comb begin
            cells_d[gi] = cells_q[gi];
            if (we && (waddr == AW'(gi))) begin
                cells_d[gi] = wbit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            cells_q <= cells_d;
        end
    end

    // Read sees the contents before the current edge.
    assign rbit = cells_q[raddr];

endmodule

// File: rtl/ebuf_judge.sv
module ebuf_judge
    import ebuf_pkg::*;
#(
    parameter int AW      = 4,
    parameter int BAL_LO  = 6,
    parameter int BAL_HI  = 10,
    parameter int LOST_LO = 2,
    parameter int LOST_HI = 14
) (
    input  logic [AW-1:0] wlat,
    input  logic [AW-1:0] rlat,
    output verdict_e      verdict
);

    logic [AW-1:0] gap;
    int            gap_i;

    always_comb begin
        gap   = wlat - rlat;
        gap_i = int'(gap);
        if ((gap_i <= LOST_LO) || (gap_i >= LOST_HI)) begin
            verdict = VERDICT_LOST;
        end else if (gap_i < BAL_LO) begin
            verdict = VERDICT_POS;
        end else if (gap_i > BAL_HI) begin
            verdict = VERDICT_NEG;
        end else begin
            verdict = VERDICT_BAL;
        end
    end

endmodule

// File: rtl/elastic_stuff_buffer.sv
module elastic_stuff_buffer
    import ebuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic wr_tick,
    input  logic rd_tick,
    input  logic word_mark,
    output logic dout,
    output logic pos_stuff,
    output logic neg_stuff_n,
    output logic reinit
);

    localparam int AW       = $clog2(DEPTH);
    localparam int BAND     = DEPTH / 8;
    localparam int BAL_LO   = DEPTH / 2 - BAND;
    localparam int BAL_HI   = DEPTH / 2 + BAND;
    localparam int LOST_LO  = BAND;
    localparam int LOST_HI  = DEPTH - BAND;
    localparam logic [AW-1:0] HALF = AW'(DEPTH / 2);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW-1:0] wlat;
        logic [AW-1:0] rlat;
        logic          hold;
        logic          dout;
        logic          mark;
        logic          judge;
        logic          reinit;
        verdict_e      verdict;
    } state_t;

    state_t   st_d;
    state_t   st_q;
    logic     rbit;
    verdict_e verdict_now;

    // Views for the bound checker.
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic          hold_q;
    assign wr_ptr_q = st_q.wptr;
    assign rd_ptr_q = st_q.rptr;
    assign hold_q   = st_q.hold;

    ebuf_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_tick),
        .waddr (st_q.wptr),
        .wbit  (din),
        .raddr (st_q.rptr),
        .rbit  (rbit)
    );

    ebuf_judge #(
        .AW      (AW),
        .BAL_LO  (BAL_LO),
        .BAL_HI  (BAL_HI),
        .LOST_LO (LOST_LO),
        .LOST_HI (LOST_HI)
    ) u_judge (
        .wlat    (st_q.wlat),
        .rlat    (st_q.rlat),
        .verdict (verdict_now)
    );

    always_comb begin
        st_d        = st_q;
        st_d.mark   = word_mark;
        st_d.judge  = 1'b0;
        st_d.reinit = 1'b0;
        st_d.dout   = st_q.hold;

        if (wr_tick) begin
            st_d.wptr = st_q.wptr + AW'(1);
        end

        // Single snapshot on the leading cycle of the word strobe.
        if (word_mark && !st_q.mark) begin
            st_d.wlat  = st_q.wptr;
            st_d.rlat  = st_q.rptr;
            st_d.judge = 1'b1;
        end

        if (st_q.judge) begin
            st_d.verdict = verdict_now;
        end

        if (st_q.judge && (verdict_now == VERDICT_LOST)) begin
            st_d.reinit = 1'b1;
            st_d.rptr   = st_d.wptr - HALF;
        end else if (rd_tick) begin
            st_d.hold = rbit;
            st_d.rptr = st_q.rptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rptr    <= HALF;
            st_q.verdict <= VERDICT_BAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout        = st_q.dout;
    assign pos_stuff   = (st_q.verdict == VERDICT_POS) && !word_mark;
    assign neg_stuff_n = (st_q.verdict != VERDICT_NEG);
    assign reinit      = st_q.reinit;

endmodule

// File: rtl/ebuf_chk.sv
module ebuf_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_tick,
    input logic          rd_tick,
    input logic          word_mark,
    input logic          dout,
    input logic          pos_stuff,
    input logic          neg_stuff_n,
    input logic          reinit,
    input logic [AW-1:0] wptr,
    input logic [AW-1:0] rptr,
    input logic          hold
);

    assert_wptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wptr == AW'($past(wptr) + AW'($past(wr_tick))));

    assert_rptr_only_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr != $past(rptr)) |-> ($past(rd_tick) || reinit));

    assert_dout_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dout == $past(hold));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_stuff && !neg_stuff_n));

    assert_pos_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_mark |-> !pos_stuff);

    assert_reinit_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !reinit);

    assert_reinit_centre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |-> (AW'(wptr - rptr) == AW'(1 << (AW - 1))));

    assert_reinit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |-> (!pos_stuff && neg_stuff_n));

endmodule

bind elastic_stuff_buffer ebuf_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_tick     (wr_tick),
    .rd_tick     (rd_tick),
    .word_mark   (word_mark),
    .dout        (dout),
    .pos_stuff   (pos_stuff),
    .neg_stuff_n (neg_stuff_n),
    .reinit      (reinit),
    .wptr        (wr_ptr_q),
    .rptr        (rd_ptr_q),
    .hold        (hold_q)
);

// File: tb/elastic_stuff_buffer_tb.sv
`timescale 1ns/1ps
module elastic_stuff_buffer_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic wr_tick = 1'b0;
    logic rd_tick = 1'b0;
    logic word_mark = 1'b0;
    logic dout, pos_stuff, neg_stuff_n, reinit;

    int n_chk = 0;
    int n_bad = 0;
    int seen_pos = 0, seen_neg = 0, seen_lost = 0, seen_masked = 0;

    // Reference model state.
    bit m_mem[16];
    int m_wp = 0, m_rp = 8, m_wlat = 0, m_rlat = 0, m_cls = 0;
    bit m_hold = 0, m_dout = 0, m_mark = 0, m_judge = 0, m_reinit = 0;

    always #2.5 clk = ~clk;

    elastic_stuff_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_tick(wr_tick),
        .rd_tick(rd_tick), .word_mark(word_mark), .dout(dout),
        .pos_stuff(pos_stuff), .neg_stuff_n(neg_stuff_n), .reinit(reinit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // 0 balanced, 1 positive, 2 negative, 3 lost (R5 bands)
    function automatic int classify(input int gap);
        if (gap <= 2 || gap >= 14) return 3;
        if (gap <= 5) return 1;
        if (gap >= 11) return 2;
        return 0;
    endfunction

    task automatic compare_outputs();
        bit exp_pos, exp_neg_n;
        exp_pos   = (m_cls == 1) && !word_mark;
        exp_neg_n = (m_cls != 2);
        chk(dout == m_dout, "R1/R2/R3 dout", int'(dout), int'(m_dout));
        chk(pos_stuff == exp_pos, "R5/R6 pos_stuff", int'(pos_stuff), int'(exp_pos));
        chk(neg_stuff_n == exp_neg_n, "R5/R7 neg_stuff_n", int'(neg_stuff_n), int'(exp_neg_n));
        chk(reinit == m_reinit, "R4/R8 reinit", int'(reinit), int'(m_reinit));
        if (m_cls == 1 && word_mark) seen_masked++;
    endtask

    task automatic step(input bit d, input bit wt, input bit rt, input bit wm);
        int o_wp, o_rp, o_wlat, o_rlat, nwp, c;
        bit o_hold, o_judge, lost;
        din = d; wr_tick = wt; rd_tick = rt; word_mark = wm;
        @(posedge clk);
        o_wp = m_wp; o_rp = m_rp; o_wlat = m_wlat; o_rlat = m_rlat;
        o_hold = m_hold; o_judge = m_judge;
        nwp = (o_wp + int'(wt)) % 16;
        lost = 1'b0;
        if (o_judge) begin
            c = classify((o_wlat - o_rlat + 16) % 16);
            m_cls = c;
            lost = (c == 3);
            if (c == 1) seen_pos++;
            if (c == 2) seen_neg++;
            if (c == 3) seen_lost++;
        end
        if (lost) begin
            m_rp = (nwp - 8 + 16) % 16;
        end else if (rt) begin
            m_hold = m_mem[o_rp];
            m_rp = (o_rp + 1) % 16;
        end
        if (wm && !m_mark) begin
            m_wlat = o_wp; m_rlat = o_rp; m_judge = 1'b1;
        end else begin
            m_judge = 1'b0;
        end
        if (wt) m_mem[o_wp] = d;
        m_wp = nwp; m_mark = wm; m_dout = o_hold; m_reinit = lost;
        #1;
        compare_outputs();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        foreach (m_mem[i]) m_mem[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk(dout == 1'b0, "R9 dout after reset", int'(dout), 0);
        chk(pos_stuff == 1'b0, "R9 pos_stuff after reset", int'(pos_stuff), 0);
        chk(neg_stuff_n == 1'b1, "R9 neg_stuff_n after reset", int'(neg_stuff_n), 1);
        chk(reinit == 1'b0, "R9 reinit after reset", int'(reinit), 0);
        rst_n = 1'b1;

        // Matched rates: gap stays at 8, balanced only (R1 R2 R3 R5).
        for (int cyc = 0; cyc < 400; cyc++)
            step($urandom_range(0, 1), cyc % 2 == 0, cyc % 2 == 0, (cyc % 40) < 3);
        chk(seen_pos == 0 && seen_neg == 0 && seen_lost == 0, "R5 balanced only",
            seen_pos + seen_neg + seen_lost, 0);

        // One read tick dropped per frame: negative stuff, then lost (R7 R8).
        for (int cyc = 0; cyc < 640; cyc++)
            step($urandom_range(0, 1), cyc % 2 == 0,
                 (cyc % 2 == 0) && (cyc % 40 != 10), (cyc % 40) < 3);
        chk(seen_neg > 0, "R7 negative verdict reached", seen_neg, 1);
        chk(seen_lost > 0, "R8 lost verdict reached on growth", seen_lost, 1);

        // One extra read tick per frame: positive stuff, masking, lost (R6 R8).
        seen_lost = 0;
        for (int cyc = 0; cyc < 640; cyc++)
            step($urandom_range(0, 1), cyc % 2 == 0,
                 (cyc % 2 == 0) || (cyc % 40 == 11), (cyc % 40) < 5);
        chk(seen_pos > 0, "R6 positive verdict reached", seen_pos, 1);
        chk(seen_masked > 0, "R6 masking exercised", seen_masked, 1);
        chk(seen_lost > 0, "R8 lost verdict reached on shrink", seen_lost, 1);

        // Random ticks and strobe lengths (R4 single latch, R8 ignored tick).
        for (int cyc = 0; cyc < 800; cyc++)
            step($urandom_range(0, 1), $urandom_range(0, 3) != 0,
                 $urandom_range(0, 3) != 0, (cyc % 30) < (cyc / 100 + 1));

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule